// File: doc/BRIEF.md
# Interrupt Level Mask Gate

This block keeps the processor's 3-bit interrupt level mask and decides whether a pending interrupt request gets through. Each request source drives one request bit and a 3-bit level. Numerically lower levels are more urgent: 0 is the most urgent and 7 the least. The block picks the most urgent pending request and admits it only when its level is strictly below the current mask. On admission it lowers the mask to that level, so later requests of the same or lower urgency are held off.

Every admission pushes the previous mask onto a four-entry save stack. A return input pops that stack to restore the mask. Software can load the mask through an 8-bit write port, of which only the low three bits are kept. The mask comes out on a read port. Reset clears the mask to 0, and a mask of 0 refuses every request until software raises it.

Top module: `ilm_gate`

## Requirements
- R1: After reset `maskOut` is 0 and `acceptPulse` and `stackErr` are low. While the mask is 0, no request is admitted.
- R2: A request is admitted only when its level is strictly less than the current mask. A request whose level equals the mask, or is above it, is refused.
- R3: Among the pending requests the one with the smallest level wins. When levels tie, the lowest source index wins.
- R4: An admission raises `acceptPulse` for exactly one cycle, in the cycle after the clock edge that sampled the request. In that cycle `acceptIdx` carries the winner's index and `maskOut` already holds the winner's level.
- R5: When `wrEn` is sampled high, `maskOut` takes `wrData[2:0]` on the next cycle and `wrData[7:3]` has no effect. No request is admitted at that edge.
- R6: When `retEn` is sampled high and the save stack is not empty, `maskOut` takes the most recently saved mask. Saved masks come back in last-in, first-out order.
- R7: The save stack holds four masks. A push onto a full stack discards the oldest entry, so the last four saved masks can still be restored.
- R8: A return with an empty save stack leaves `maskOut` unchanged and raises `stackErr` for one cycle, in the cycle after the edge that sampled `retEn`.
- R9: When events coincide at one edge, a software write takes precedence over a return, and a return takes precedence over an admission. Only the event with precedence takes effect at that edge.
- R10: Source i's level is read from `reqLvl[3*i+2:3*i]`, and its request bit is `reqVec[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqVec | input | 8 | Request bit for each source |
| reqLvl | input | 24 | Packed 3-bit level for each source |
| wrEn | input | 1 | Software mask write strobe |
| wrData | input | 8 | Write value; only the low 3 bits are kept |
| retEn | input | 1 | Return-from-interrupt strobe; pops the save stack |
| maskOut | output | 3 | Current interrupt level mask |
| acceptPulse | output | 1 | One-cycle admission pulse |
| acceptIdx | output | 3 | Index of the admitted source |
| stackErr | output | 1 | One-cycle pulse for a return on an empty stack |

## Verification
Arbitration is tried with three kinds of pattern, and each tells a different fault apart.
- A single request at a level equal to the mask, then one level below it, separates the strict test from a less-than-or-equal test.
- Several requests at the same level against one at a more urgent level show whether the level comparison or the index order decides the winner.
- Chains of admissions and returns, including more than four pushes and a pop from an empty stack, expose stack order, loss of the oldest entry and the error pulse.

Cycles where a write, a return and a request coincide check the precedence. A long stretch of random stimulus, compared against a reference model, covers mixed sequences.

// File: rtl/ilm_pkg.sv
package ilm_pkg;
  // Strobes from the control to the datapath. At most one is set in a cycle.
  typedef struct packed {
    logic loadWrite;   // software write of the mask
    logic loadAccept;  // admit the winner, push the old mask
    logic doPop;       // restore the mask from the save stack
    logic popErr;      // return seen while the stack is empty
  } ctrlStrobes_t;
endpackage

// File: rtl/ilm_arbiter.sv
module ilm_arbiter #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]       reqVec,
  input  logic [NUM_SRC*LVL_W-1:0] reqLvl,
  output logic                     winValid,
  output logic [IDX_W-1:0]         winIdx,
  output logic [LVL_W-1:0]         winLvl
);
  logic [LVL_W-1:0] lvlArr [NUM_SRC];

  // Split the packed level bus into one level per source.
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSlice
    assign lvlArr[g] = reqLvl[g*LVL_W +: LVL_W];
  end

  // Scan upward in index order. A later source replaces the current winner
  // only with a strictly smaller level, so the lowest index wins a tie.
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    winLvl   = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (reqVec[i] && (!winValid || (lvlArr[i] < winLvl))) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(i);
        winLvl   = lvlArr[i];
      end
    end
  end
endmodule

// File: rtl/ilm_ctrl.sv
module ilm_ctrl
  import ilm_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic             retEn,
  input  logic             winValid,
  input  logic [LVL_W-1:0] winLvl,
  input  logic [LVL_W-1:0] maskVal,
  input  logic             stackEmpty,
  output ctrlStrobes_t     strobes
);
  logic admitOk;

  // Strict comparison: a level equal to the mask is refused.
  assign admitOk = winValid && (winLvl < maskVal);

  // Precedence: software write, then return, then admission.
  always_comb begin
    strobes = '0;
    if (wrEn) begin
      strobes.loadWrite = 1'b1;
    end else if (retEn) begin
      if (stackEmpty) strobes.popErr = 1'b1;
      else            strobes.doPop  = 1'b1;
    end else if (admitOk) begin
      strobes.loadAccept = 1'b1;
    end
  end

  // R9: at most one action per edge
  a_r9_single_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));
endmodule

// File: rtl/ilm_datapath.sv
module ilm_datapath
  import ilm_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int IDX_W = 3,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     strobes,
  input  logic [LVL_W-1:0] wrLvl,
  input  logic [IDX_W-1:0] winIdx,
  input  logic [LVL_W-1:0] winLvl,
  output logic [LVL_W-1:0] maskReg,
  output logic             stackEmpty,
  output logic             acceptPulse,
  output logic [IDX_W-1:0] acceptIdx,
  output logic             errPulse
);
  logic [LVL_W-1:0] stackMem [DEPTH];
  logic [LVL_W-1:0] upSrc    [DEPTH];
  logic [LVL_W-1:0] dnSrc    [DEPTH];
  logic [CNT_W-1:0] fillCnt;

  assign stackEmpty = (fillCnt == '0);

  // The save stack is a shift register with entry 0 on top. A push shifts
  // everything down and drops the bottom entry. A pop shifts up.
  for (genvar g = 0; g < DEPTH; g++) begin : gStack
    if (g == 0) begin : gTop
      assign upSrc[g] = maskReg;
    end else begin : gMid
      assign upSrc[g] = stackMem[g-1];
    end
    if (g == DEPTH - 1) begin : gBot
      assign dnSrc[g] = '0;
    end else begin : gInner
      assign dnSrc[g] = stackMem[g+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  stackMem[g] <= '0;
      else if (strobes.loadAccept) stackMem[g] <= upSrc[g];
      else if (strobes.doPop)      stackMem[g] <= dnSrc[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fillCnt <= '0;
    end else if (strobes.loadAccept) begin
      if (fillCnt != CNT_W'(DEPTH)) fillCnt <= fillCnt + 1'b1;
    end else if (strobes.doPop) begin
      fillCnt <= fillCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  maskReg <= '0;
    else if (strobes.loadWrite)  maskReg <= wrLvl;
    else if (strobes.loadAccept) maskReg <= winLvl;
    else if (strobes.doPop)      maskReg <= stackMem[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acceptPulse <= 1'b0;
      acceptIdx   <= '0;
      errPulse    <= 1'b0;
    end else begin
      acceptPulse <= strobes.loadAccept;
      acceptIdx   <= strobes.loadAccept ? winIdx : '0;
      errPulse    <= strobes.popErr;
    end
  end

  // R2: an admission always leaves a strictly lower mask than before
  a_r2_strict_drop: assert property (@(posedge clk) disable iff (!rst_n)
    acceptPulse |-> (maskReg < $past(maskReg)));

  // R8: a pop from an empty stack keeps the mask
  a_r8_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    errPulse |-> (maskReg == $past(maskReg)));

  // R7: the fill count never exceeds the stack depth
  a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fillCnt <= CNT_W'(DEPTH));

  // R4: the accept and error pulses never occur together
  a_r4_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(acceptPulse && errPulse));
endmodule

// File: rtl/ilm_gate.sv
module ilm_gate
  import ilm_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  parameter int WR_W    = 8,
  parameter int DEPTH   = 4,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       reqVec,
  input  logic [NUM_SRC*LVL_W-1:0] reqLvl,
  input  logic                     wrEn,
  input  logic [WR_W-1:0]          wrData,
  input  logic                     retEn,
  output logic [LVL_W-1:0]         maskOut,
  output logic                     acceptPulse,
  output logic [IDX_W-1:0]         acceptIdx,
  output logic                     stackErr
);
  logic             winValid;
  logic [IDX_W-1:0] winIdx;
  logic [LVL_W-1:0] winLvl;
  logic             stackEmpty;
  ctrlStrobes_t     strobes;
  logic             unusedWrHi;

  // Bits of the write value above the mask width are dropped.
  assign unusedWrHi = ^wrData[WR_W-1:LVL_W];

  ilm_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
    .reqVec(reqVec), .reqLvl(reqLvl),
    .winValid(winValid), .winIdx(winIdx), .winLvl(winLvl)
  );

  ilm_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .retEn(retEn),
    .winValid(winValid), .winLvl(winLvl), .maskVal(maskOut),
    .stackEmpty(stackEmpty), .strobes(strobes)
  );

  ilm_datapath #(.LVL_W(LVL_W), .IDX_W(IDX_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .wrLvl(wrData[LVL_W-1:0]), .winIdx(winIdx), .winLvl(winLvl),
    .maskReg(maskOut), .stackEmpty(stackEmpty),
    .acceptPulse(acceptPulse), .acceptIdx(acceptIdx), .errPulse(stackErr)
  );

  // R5: a write loads the low bits and blocks admission at that edge
  a_r5_write_load: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> (!acceptPulse && (maskOut == $past(wrData[LVL_W-1:0]))));

  // R1: a zero mask admits nothing
  a_r1_zero_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (maskOut == '0) |=> !acceptPulse);
endmodule

// File: tb/ilm_gate_tb.sv
module ilm_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reqVec = '0;
  logic [23:0] reqLvl = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic        retEn = 1'b0;
  logic [2:0]  maskOut;
  logic        acceptPulse;
  logic [2:0]  acceptIdx;
  logic        stackErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] mask;
    logic       acc;
    logic [2:0] idx;
    logic       err;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  // Reference model state
  int mMask = 0;
  int mStk[4];
  int mCnt = 0;

  // Stimulus staging
  logic [7:0]  nReq;
  logic [23:0] nLvl;

  always #2 clk = ~clk;   // 250 MHz

  ilm_gate u_dut (
    .clk(clk), .rst_n(rst_n), .reqVec(reqVec), .reqLvl(reqLvl),
    .wrEn(wrEn), .wrData(wrData), .retEn(retEn),
    .maskOut(maskOut), .acceptPulse(acceptPulse), .acceptIdx(acceptIdx),
    .stackErr(stackErr)
  );

  task automatic clrReq();
    nReq = '0;
    nLvl = '0;
  endtask

  // R10: source s uses reqVec[s] and reqLvl[3*s+2:3*s]
  task automatic addReq(input int s, input int l);
    nReq[s] = 1'b1;
    nLvl[s*3 +: 3] = 3'(l);
  endtask

  // Driver: applies one cycle of inputs and queues the expected outcome.
  task automatic step(input logic wr, input logic [7:0] wd, input logic rt,
                      input string tag);
    expItem_t e;
    int best;
    int bestIdx;
    @(negedge clk);
    reqVec = nReq; reqLvl = nLvl; wrEn = wr; wrData = wd; retEn = rt;
    e.acc = 1'b0; e.err = 1'b0; e.idx = '0; e.tag = tag;
    if (wr) begin
      mMask = int'(wd[2:0]);
    end else if (rt) begin
      if (mCnt == 0) e.err = 1'b1;
      else begin
        mMask = mStk[0];
        for (int i = 0; i < 3; i++) mStk[i] = mStk[i+1];
        mStk[3] = 0;
        mCnt--;
      end
    end else begin
      best = 8; bestIdx = 0;
      for (int i = 0; i < 8; i++)
        if (nReq[i] && int'(nLvl[i*3 +: 3]) < best) begin
          best = int'(nLvl[i*3 +: 3]); bestIdx = i;
        end
      if (best < mMask) begin
        for (int i = 3; i > 0; i--) mStk[i] = mStk[i-1];
        mStk[0] = mMask;
        if (mCnt < 4) mCnt++;
        mMask = best;
        e.acc = 1'b1;
        e.idx = 3'(bestIdx);
      end
    end
    e.mask = 3'(mMask);
    expQ.push_back(e);
  endtask

  task automatic idle(input string tag);
    clrReq();
    step(1'b0, 8'h00, 1'b0, tag);
  endtask

  // Monitor: compares one queued item per clock, after the edge settles.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (maskOut !== e.mask || acceptPulse !== e.acc || stackErr !== e.err ||
          (e.acc && acceptIdx !== e.idx)) begin
        errors++;
        $display("FAIL %s: actual mask=%0d acc=%0b idx=%0d err=%0b expected mask=%0d acc=%0b idx=%0d err=%0b",
                 e.tag, maskOut, acceptPulse, acceptIdx, stackErr,
                 e.mask, e.acc, e.idx, e.err);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL R4 watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 4; i++) mStk[i] = 0;
    clrReq();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (maskOut !== 3'd0 || acceptPulse !== 1'b0 || stackErr !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual mask=%0d acc=%0b err=%0b expected 0 0 0",
               maskOut, acceptPulse, stackErr);
    end

    clrReq(); addReq(3, 0); step(1'b0, 8'h00, 1'b0, "R1 zero mask blocks level 0");
    clrReq(); step(1'b1, 8'hFD, 1'b0, "R5 write keeps low bits (0xFD->5)");
    clrReq(); addReq(2, 5); step(1'b0, 8'h00, 1'b0, "R2 equal level refused");
    clrReq(); addReq(2, 6); step(1'b0, 8'h00, 1'b0, "R2 higher level refused");
    clrReq(); addReq(6, 6); addReq(5, 4); addReq(2, 4);
    step(1'b0, 8'h00, 1'b0, "R3 tie goes to lowest index, R4 mask load");
    idle("R4 pulse lasts one cycle");
    clrReq(); addReq(0, 3); addReq(7, 1);
    step(1'b0, 8'h00, 1'b0, "R3 smallest level wins over lower index");
    clrReq(); addReq(3, 0); step(1'b0, 8'h00, 1'b0, "R4 admit level 0");
    clrReq(); addReq(1, 0); step(1'b0, 8'h00, 1'b0, "R1 mask 0 blocks again");
    clrReq(); step(1'b0, 8'h00, 1'b1, "R6 pop restores 1");
    clrReq(); step(1'b0, 8'h00, 1'b1, "R6 pop restores 4");
    clrReq(); step(1'b0, 8'h00, 1'b1, "R6 pop restores 5");
    clrReq(); step(1'b0, 8'h00, 1'b1, "R8 empty pop error, mask held");
    idle("R8 error pulse one cycle");

    // R7: five pushes onto a four-deep stack
    clrReq(); step(1'b1, 8'h07, 1'b0, "R5 write 7");
    for (int l = 6; l >= 2; l--) begin
      clrReq(); addReq(l, l); step(1'b0, 8'h00, 1'b0, "R7 push chain");
    end
    for (int k = 0; k < 4; k++) begin
      clrReq(); step(1'b0, 8'h00, 1'b1, "R7 pop after overflow");
    end
    clrReq(); step(1'b0, 8'h00, 1'b1, "R7 oldest entry discarded");

    // R9: precedence
    clrReq(); addReq(4, 0); step(1'b1, 8'h06, 1'b1, "R9 write beats return and request");
    clrReq(); addReq(4, 1); step(1'b0, 8'h00, 1'b0, "R9 admit after write");
    clrReq(); addReq(5, 0); step(1'b0, 8'h00, 1'b1, "R9 return beats request");
    clrReq(); addReq(5, 0); step(1'b0, 8'h00, 1'b1, "R9 empty return beats request");

    // Mixed random stretch
    for (int n = 0; n < 400; n++) begin
      int r;
      clrReq();
      for (int s = 0; s < 8; s++)
        if ($urandom_range(0, 2) == 0) addReq(s, int'($urandom_range(0, 7)));
      r = int'($urandom_range(0, 9));
      step(r == 0, 8'($urandom), r == 1 || r == 2, "R3 random mix");
    end

    idle("R4 final idle");
    @(negedge clk);
    @(negedge clk);
    finishRun();
  end
endmodule